// File: doc/BRIEF.md
# Datapath Arithmetic Unit with Zero-Test Flag

This block is the arithmetic stage of a bus-oriented multi-cycle datapath. Each cycle the controller picks a left operand (the constant one, the whole data bus word, or a signed byte taken from the low bits of the data bus) and an operation. The right operand is always the address bus word. The computed word can be captured into a result register. Its OR-reduction can be captured into a one-bit flag register. The two captures have separate enables.

The flag is used for equality branches. The controller subtracts two operands with the flag capture enabled, so a cleared flag means the operands were equal. The block then combines an unconditional program-counter write request with a conditional one that is honoured only while the flag is clear. Both registers clear on reset. Arithmetic wraps at the word width and raises no carry or overflow indication.

Top module: `alu_cond_unit`

## Requirements
- R1: While rst_ni is low, res_o is 0 and zflag_o is 0.
- R2: Operation code 2'b00 (pass) produces the left operand unchanged.
- R3: Operation code 2'b01 produces left + right, truncated to 32 bits.
- R4: Operation code 2'b10 produces left - right (left operand minus address bus), truncated to 32 bits.
- R5: Operation code 2'b11 produces the bitwise inverse of (left AND right).
- R6: Left select 2'b00 makes the left operand the constant 1.
- R7: Left select 2'b10 makes the left operand data_bus_i[7:0] sign-extended to 32 bits. Bits 31:8 of the data bus have no effect.
- R8: Left select 2'b01 makes the left operand the full data bus. The unused code 2'b11 behaves the same way.
- R9: On a rising clock edge with res_we_i high, res_o takes the computed word. With res_we_i low, res_o keeps its value.
- R10: On a rising clock edge with flag_we_i high, zflag_o takes 1 if any bit of the computed word is 1 and 0 otherwise. With flag_we_i low, zflag_o keeps its value.
- R11: pc_we_o equals pc_wr_i OR (pc_wr_cond_i AND NOT zflag_o), combinationally.
- R12: The two captures are independent. A flag capture leaves res_o unchanged, and a result capture leaves zflag_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alu_op_i | input | 2 | Operation: 00 pass, 01 add, 10 subtract, 11 nand |
| lsel_i | input | 2 | Left operand: 00 one, 01 bus, 10 signed byte, 11 bus |
| data_bus_i | input | 32 | Data bus word |
| addr_bus_i | input | 32 | Address bus word, right operand |
| res_we_i | input | 1 | Result register capture enable |
| flag_we_i | input | 1 | Flag register capture enable |
| pc_wr_i | input | 1 | Unconditional PC write request |
| pc_wr_cond_i | input | 1 | PC write request taken only when flag is 0 |
| res_o | output | 32 | Result register |
| zflag_o | output | 1 | Flag register, OR of captured word |
| pc_we_o | output | 1 | PC write enable |

## Verification
The bench drives subtractions of equal and unequal operands with the flag capture enabled. A flag built from the wrong polarity, or from only part of the word, gives the wrong branch decision. It also drives additions and subtractions that cross the word boundary, where a carry leaking into the result would show up. For the signed byte select it uses bytes with the top bit set and upper data bus bits set to noise, which exposes zero extension or an unmasked bus. It toggles each capture enable alone, so a result register that follows the flag enable, or the reverse, becomes visible. It steps every combination of the PC requests against both flag values.

// File: rtl/alu_cond_pkg.sv
package alu_cond_pkg;
  typedef enum logic [1:0] {
    OP_PASS = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_NAND = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    LSEL_ONE  = 2'b00,
    LSEL_BUS  = 2'b01,
    LSEL_SEXT = 2'b10,
    LSEL_RSVD = 2'b11
  } lsel_e;
endpackage

// File: rtl/alu_lmux.sv
module alu_lmux
  import alu_cond_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IMM_W = 8
) (
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] left_o
);
  localparam int EXT_W = DW - IMM_W;

  logic [DW-1:0] sext;
  logic [DW-1:0] one;

  assign sext = {{EXT_W{bus_i[IMM_W-1]}}, bus_i[IMM_W-1:0]};
  assign one  = {{(DW-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (lsel_e'(sel_i))
      LSEL_ONE:  left_o = one;
      LSEL_SEXT: left_o = sext;
      default:   left_o = bus_i; // bus and reserved code
    endcase
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_cond_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o,
  output logic          nz_o
);
  logic [DW-1:0] nand_w;

  for (genvar i = 0; i < DW; i++) begin : g_nand
    assign nand_w[i] = ~(a_i[i] & b_i[i]);
  end

  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_PASS: y_o = a_i;
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      default: y_o = nand_w;
    endcase
  end

  assign nz_o = |y_o;
endmodule

// File: rtl/alu_state_regs.sv
module alu_state_regs #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          res_we_i,
  input  logic          flag_we_i,
  input  logic [DW-1:0] y_i,
  input  logic          nz_i,
  output logic [DW-1:0] res_o,
  output logic          flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_o <= '0;
    else if (res_we_i) res_o <= y_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else if (flag_we_i) flag_o <= nz_i;
  end
endmodule

// File: rtl/alu_cond_unit.sv
module alu_cond_unit
  import alu_cond_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IMM_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    alu_op_i,
  input  logic [1:0]    lsel_i,
  input  logic [DW-1:0] data_bus_i,
  input  logic [DW-1:0] addr_bus_i,
  input  logic          res_we_i,
  input  logic          flag_we_i,
  input  logic          pc_wr_i,
  input  logic          pc_wr_cond_i,
  output logic [DW-1:0] res_o,
  output logic          zflag_o,
  output logic          pc_we_o
);
  logic [DW-1:0] left_w;
  logic [DW-1:0] y_w;
  logic          nz_w;

  alu_lmux #(.DW(DW), .IMM_W(IMM_W)) u_lmux (
    .sel_i (lsel_i),
    .bus_i (data_bus_i),
    .left_o(left_w)
  );

  alu_core #(.DW(DW)) u_core (
    .op_i(alu_op_i),
    .a_i (left_w),
    .b_i (addr_bus_i),
    .y_o (y_w),
    .nz_o(nz_w)
  );

  alu_state_regs #(.DW(DW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .res_we_i (res_we_i),
    .flag_we_i(flag_we_i),
    .y_i      (y_w),
    .nz_i     (nz_w),
    .res_o    (res_o),
    .flag_o   (zflag_o)
  );

  // conditional request honoured only on an equal compare (flag clear)
  assign pc_we_o = pc_wr_i | (pc_wr_cond_i & ~zflag_o);
endmodule

// File: rtl/alu_cond_unit_chk.sv
module alu_cond_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    alu_op_i,
  input logic [1:0]    lsel_i,
  input logic [DW-1:0] data_bus_i,
  input logic [DW-1:0] addr_bus_i,
  input logic          res_we_i,
  input logic          flag_we_i,
  input logic          pc_wr_i,
  input logic          pc_wr_cond_i,
  input logic [DW-1:0] res_o,
  input logic          zflag_o,
  input logic          pc_we_o
);
  always_comb begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (res_o == '0 && !zflag_o); // R1
    end
  end

  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_we_i |=> $stable(res_o)); // R9

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(zflag_o)); // R10

  AST_ADD_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_we_i && alu_op_i == 2'b01 && lsel_i == 2'b01)
    |=> res_o == $past(data_bus_i + addr_bus_i)); // R3

  AST_SUB_EQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && alu_op_i == 2'b10 && lsel_i == 2'b01 && data_bus_i == addr_bus_i)
    |=> !zflag_o); // R10

  AST_PC_UNCOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr_i |-> pc_we_o); // R11

  AST_PC_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr_cond_i && !zflag_o) |-> pc_we_o); // R11

  AST_PC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pc_wr_i && (!pc_wr_cond_i || zflag_o)) |-> !pc_we_o); // R11
endmodule

bind alu_cond_unit alu_cond_unit_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .alu_op_i    (alu_op_i),
  .lsel_i      (lsel_i),
  .data_bus_i  (data_bus_i),
  .addr_bus_i  (addr_bus_i),
  .res_we_i    (res_we_i),
  .flag_we_i   (flag_we_i),
  .pc_wr_i     (pc_wr_i),
  .pc_wr_cond_i(pc_wr_cond_i),
  .res_o       (res_o),
  .zflag_o     (zflag_o),
  .pc_we_o     (pc_we_o)
);

// File: tb/sim_alu_cond_unit.sv
module sim_alu_cond_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    op, lsel;
  logic [DW-1:0] dbus, abus;
  logic          res_we, flag_we, pc_wr, pc_wr_cond;
  logic [DW-1:0] res;
  logic          zflag, pc_we;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_cond_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .alu_op_i(op), .lsel_i(lsel),
    .data_bus_i(dbus), .addr_bus_i(abus), .res_we_i(res_we),
    .flag_we_i(flag_we), .pc_wr_i(pc_wr), .pc_wr_cond_i(pc_wr_cond),
    .res_o(res), .zflag_o(zflag), .pc_we_o(pc_we)
  );

  task automatic chk32(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one capture cycle: drive, clock, sample 1 time unit later
  task automatic cycle(logic [1:0] o, logic [1:0] s, logic [DW-1:0] d,
                       logic [DW-1:0] a, logic rwe, logic fwe);
    op = o; lsel = s; dbus = d; abus = a; res_we = rwe; flag_we = fwe;
    @(posedge clk); #1;
    res_we = 1'b0; flag_we = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cycle(2'b01, 2'b01, 32'h1234_5678, 32'h1, 1'b1, 1'b1);
    chk32("R1 res", res, 32'h0);
    chk32("R1 flag", {31'b0, zflag}, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_ops;
    cycle(2'b00, 2'b01, 32'hDEAD_BEEF, 32'h5555_5555, 1'b1, 1'b0);
    chk32("R2 pass", res, 32'hDEAD_BEEF);
    cycle(2'b01, 2'b01, 32'h0000_1000, 32'h0000_0234, 1'b1, 1'b0);
    chk32("R3 add", res, 32'h0000_1234);
    cycle(2'b01, 2'b01, 32'hFFFF_FFFF, 32'h0000_0003, 1'b1, 1'b0);
    chk32("R3 add wrap", res, 32'h0000_0002);
    cycle(2'b10, 2'b01, 32'h0000_0010, 32'h0000_0003, 1'b1, 1'b0);
    chk32("R4 sub", res, 32'h0000_000D);
    cycle(2'b10, 2'b01, 32'h0000_0001, 32'h0000_0002, 1'b1, 1'b0);
    chk32("R4 sub wrap", res, 32'hFFFF_FFFF);
    cycle(2'b11, 2'b01, 32'hF0F0_FF00, 32'hFF00_F0F0, 1'b1, 1'b0);
    chk32("R5 nand", res, 32'h0FFF_0FFF);
  endtask

  task automatic t_lsel;
    cycle(2'b01, 2'b00, 32'hABCD_0000, 32'h0000_0041, 1'b1, 1'b0);
    chk32("R6 one", res, 32'h0000_0042);
    cycle(2'b00, 2'b10, 32'h1234_5680, 32'h0, 1'b1, 1'b0);
    chk32("R7 sext neg", res, 32'hFFFF_FF80);
    cycle(2'b01, 2'b10, 32'hFFFF_FF7F, 32'h0000_0001, 1'b1, 1'b0);
    chk32("R7 sext pos upper ignored", res, 32'h0000_0080);
    cycle(2'b01, 2'b10, 32'h0000_00FC, 32'h0000_0068, 1'b1, 1'b0);
    chk32("R7 sext offset", res, 32'h0000_0064);
    cycle(2'b00, 2'b11, 32'h8765_4321, 32'h0, 1'b1, 1'b0);
    chk32("R8 reserved as bus", res, 32'h8765_4321);
  endtask

  task automatic t_enables;
    cycle(2'b00, 2'b01, 32'h1111_1111, 32'h0, 1'b1, 1'b0);
    cycle(2'b00, 2'b01, 32'h2222_2222, 32'h0, 1'b0, 1'b0);
    chk32("R9 hold", res, 32'h1111_1111);
    cycle(2'b10, 2'b01, 32'h0000_0007, 32'h0000_0005, 1'b0, 1'b1);
    chk32("R10 flag unequal", {31'b0, zflag}, 32'h1);
    chk32("R12 res untouched by flag", res, 32'h1111_1111);
    cycle(2'b10, 2'b01, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b0);
    chk32("R10 flag hold", {31'b0, zflag}, 32'h1);
    cycle(2'b10, 2'b01, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1);
    chk32("R10 flag equal", {31'b0, zflag}, 32'h0);
    cycle(2'b00, 2'b01, 32'h8000_0000, 32'h0, 1'b0, 1'b1);
    chk32("R10 flag msb only", {31'b0, zflag}, 32'h1);
    cycle(2'b00, 2'b01, 32'h0, 32'h0, 1'b1, 1'b0);
    chk32("R12 flag untouched by res", {31'b0, zflag}, 32'h1);
    chk32("R9 load zero", res, 32'h0);
  endtask

  task automatic t_pcwe;
    for (int f = 0; f < 2; f++) begin
      // f=0: flag clear via equal compare, f=1: flag set
      cycle(2'b10, 2'b01, 32'h5, (f == 0) ? 32'h5 : 32'h6, 1'b0, 1'b1);
      for (int k = 0; k < 4; k++) begin
        pc_wr = k[0]; pc_wr_cond = k[1]; #1;
        chk32("R11 pc_we", {31'b0, pc_we},
              {31'b0, k[0] | (k[1] & (f == 0))});
      end
      pc_wr = 1'b0; pc_wr_cond = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op = 0; lsel = 0; dbus = 0; abus = 0;
    res_we = 0; flag_we = 0; pc_wr = 0; pc_wr_cond = 0;
    #2;
    t_reset;
    t_ops;
    t_lsel;
    t_enables;
    t_pcwe;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule